// File: doc/BRIEF.md
# Indexed UART control register file

This block is the host-facing register set of one UART channel. A host sees only an 8-byte window with a 3-bit address and byte-wide data. A few additional control registers do not fit in that window. They are reached indirectly: the host loads an offset at one address and then reads or writes the selected register through a data port at another address. The block keeps the divisor, line-control, interrupt-enable and modem-control registers. It forwards transmit bytes as a one-cycle write strobe and drives the serial output and the active-low modem handshake outputs from registered values.

Three kinds of reset are handled. A synchronous hardware reset restores every writable register. A soft reset, triggered through a bit of the indexed configuration register, has the same effect. A channel reset, triggered by writing zero to the indexed channel-reset register, has the same effect except that it leaves the two clock-selection registers alone. The block holds a snapshot of the status reported by the shifters and FIFOs, loaded on an update strobe. Every reset forces that snapshot to its idle values, so the status reads back in its reset state until the next update.

Top module: `ixreg_uart_regs`

## Requirements
- R1: After any reset, every writable register reads 0x00, except that the divisor low byte reads 0x01 and the prescaler (indexed offset 0x01) reads 0x20. The status snapshot reads as follows: line status (offset 0x08) 0x60, interrupt status (address 2) 0x01, receive level (offset 0x09) 0 and transmit level (offset 0x0A) 0.
- R2: While the hardware reset is high and after it falls, sout, rts_n and dtr_n are 1 until software changes the controlling registers.
- R3: A write to address 7 loads the offset register, which reads back at address 7. A write to address 5 writes the indexed register that the offset selects. The writable offsets are 0x00 (access control), 0x01 (prescaler), 0x02 and 0x03 (clock selections) and 0x04 (configuration).
- R4: A read of address 5 returns the indexed register only while bit 6 of the access-control register (offset 0x00) is 1. While that bit is 0, the read returns rx_hold.
- R5: While the line-control register (address 3) holds 0xBF, writes to addresses 5 and 7 change nothing and reads of addresses 5 and 7 return 0x00.
- R6: Offsets other than 0x00-0x05 and 0x08-0x0A are reserved: writes to them have no effect and reads return 0x00. Offsets 0x08-0x0A are read-only, and offset 0x05 reads 0x00.
- R7: Writing the configuration register (offset 0x04) with bit 7 set applies a full reset one cycle later, clock selections included. Writes without bit 7 are stored, and bit 7 always reads 0.
- R8: Writing 0x00 to offset 0x05 applies a reset one cycle later that restores everything as in R1 except offsets 0x02 and 0x03, which keep their values. A nonzero write to offset 0x05 has no effect.
- R9: The modem status at address 6 reads {dcd_i, ri_i, dsr_i, cts_i} in bits 7 down to 4, taken live. Bits 3:0 are the last st_mdelta loaded and read 0 after reset.
- R10: A one-cycle st_upd loads st_line, st_irq, st_rxlvl, st_txlvl and st_mdelta into the snapshot. Until the next update, the snapshot holds those values.
- R11: With line-control bit 7 set, addresses 0 and 1 access the divisor low and high bytes. With it clear, address 1 is the interrupt enable, a read of address 0 returns rx_hold, and a write to address 0 raises thr_wr for one cycle with thr_wdata equal to the written byte.
- R12: One cycle after the registers change, dtr_n is the inverse of modem-control bit 0 and rts_n is the inverse of bit 1. sout is 0 while line-control bit 6 is set and follows tx_serial otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 3 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| rx_hold | input | 8 | Receive holding data from the receive path |
| st_upd | input | 1 | Status snapshot load strobe |
| st_line | input | 8 | Line status from the channel |
| st_irq | input | 8 | Interrupt status from the channel |
| st_rxlvl | input | 7 | Receive FIFO level |
| st_txlvl | input | 7 | Transmit FIFO level |
| st_mdelta | input | 4 | Modem-line change flags |
| dcd_i | input | 1 | Carrier detect line |
| ri_i | input | 1 | Ring indicator line |
| dsr_i | input | 1 | Data set ready line |
| cts_i | input | 1 | Clear to send line |
| tx_serial | input | 1 | Serial bit from the transmit shifter |
| thr_wr | output | 1 | One-cycle transmit byte strobe |
| thr_wdata | output | 8 | Transmit byte |
| sout | output | 1 | Serial output, idle high |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Data terminal ready, active low |

## Verification
The indexed bank is driven with a seeded random mix of offsets. The mix covers the writable, read-only, write-only and reserved ranges, so a decode slip shows up either as a stored value in a reserved slot or as a lost value in a real one. The three resets are each applied after the clock selections, the prescaler and the divisor have been set to non-default values. This shows which registers each reset kind restores and which ones survive the channel reset. The port at address 5 is read with the read-enable bit both set and clear, and again under the 0xBF lockout. This separates the indexed path, the receive path and the blocked path, because each returns a distinct value.

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;
  localparam int DW   = 8;
  localparam int AW   = 3;
  localparam int OW   = 8;
  localparam int LVLW = 7;
  localparam int DLTW = 4;
  localparam int MCRW = 2;

  localparam logic [AW-1:0] A_RXTX = 3'd0;
  localparam logic [AW-1:0] A_IER  = 3'd1;
  localparam logic [AW-1:0] A_ISR  = 3'd2;
  localparam logic [AW-1:0] A_LCR  = 3'd3;
  localparam logic [AW-1:0] A_MCR  = 3'd4;
  localparam logic [AW-1:0] A_IDX  = 3'd5;
  localparam logic [AW-1:0] A_MSR  = 3'd6;
  localparam logic [AW-1:0] A_OFS  = 3'd7;

  localparam int N_RW    = 5;
  localparam int OFF_ACR = 0;
  localparam int OFF_CPR = 1;
  localparam int OFF_CKS = 2;
  localparam int OFF_CKA = 3;
  localparam int OFF_COR = 4;
  localparam int OFF_CSR = 5;
  localparam int OFF_LSR = 8;
  localparam int OFF_RFL = 9;
  localparam int OFF_TFL = 10;

  localparam int RDEN_BIT  = 6;
  localparam int SRST_BIT  = 7;
  localparam int DLAB_BIT  = 7;
  localparam int BRK_BIT   = 6;

  localparam logic [DW-1:0] LCR_LOCK = 8'hBF;
  localparam logic [DW-1:0] DLL_RST  = 8'h01;
  localparam logic [DW-1:0] CPR_RST  = 8'h20;
  localparam logic [DW-1:0] LSR_RST  = 8'h60;
  localparam logic [DW-1:0] ISR_RST  = 8'h01;

  typedef struct packed {
    logic full;
    logic chan;
  } rst_req_t;

  function automatic logic [DW-1:0] rw_rst_val(input int idx);
    return (idx == OFF_CPR) ? CPR_RST : '0;
  endfunction

  function automatic logic rw_keeps_on_chan(input int idx);
    return (idx == OFF_CKS) || (idx == OFF_CKA);
  endfunction
endpackage

// File: rtl/ixreg_rst_ctl.sv
module ixreg_rst_ctl
  import ixreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     soft_trig,
  input  logic     chan_trig,
  output rst_req_t req
);
  logic soft_q;
  logic chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b0;
      chan_q <= 1'b0;
    end else begin
      soft_q <= soft_trig;
      chan_q <= chan_trig & ~soft_trig;
    end
  end

  always_comb begin
    req.full = rst | soft_q;
    req.chan = chan_q;
  end
endmodule

// File: rtl/ixreg_bank.sv
module ixreg_bank
  import ixreg_pkg::*;
#(
  parameter int BDW  = DW,
  parameter int BOW  = OW,
  parameter int NREG = N_RW
) (
  input  logic                      clk,
  input  rst_req_t                  req,
  input  logic                      we,
  input  logic [BOW-1:0]            off,
  input  logic [BDW-1:0]            wdata,
  output logic [NREG-1:0][BDW-1:0]  regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [BDW-1:0] RV    = BDW'(rw_rst_val(i));
    localparam logic           KEEP  = rw_keeps_on_chan(i);
    localparam logic [BDW-1:0] WMASK = (i == OFF_COR) ? ~(BDW'(1) << SRST_BIT) : '1;
    logic sel;
    assign sel = we && (off == BOW'(i));

    always_ff @(posedge clk) begin
      if (req.full || (req.chan && !KEEP)) begin
        regs[i] <= RV;
      end else if (sel) begin
        regs[i] <= wdata & WMASK;
      end
    end
  end
endmodule

// File: rtl/ixreg_status.sv
module ixreg_status
  import ixreg_pkg::*;
#(
  parameter int SDW  = DW,
  parameter int SLW  = LVLW,
  parameter int SDLW = DLTW
) (
  input  logic            clk,
  input  rst_req_t        req,
  input  logic            upd,
  input  logic [SDW-1:0]  line_i,
  input  logic [SDW-1:0]  irq_i,
  input  logic [SLW-1:0]  rxlvl_i,
  input  logic [SLW-1:0]  txlvl_i,
  input  logic [SDLW-1:0] mdelta_i,
  output logic [SDW-1:0]  line_q,
  output logic [SDW-1:0]  irq_q,
  output logic [SLW-1:0]  rxlvl_q,
  output logic [SLW-1:0]  txlvl_q,
  output logic [SDLW-1:0] mdelta_q
);
  always_ff @(posedge clk) begin
    if (req.full || req.chan) begin
      line_q   <= SDW'(LSR_RST);
      irq_q    <= SDW'(ISR_RST);
      rxlvl_q  <= '0;
      txlvl_q  <= '0;
      mdelta_q <= '0;
    end else if (upd) begin
      line_q   <= line_i;
      irq_q    <= irq_i;
      rxlvl_q  <= rxlvl_i;
      txlvl_q  <= txlvl_i;
      mdelta_q <= mdelta_i;
    end
  end
endmodule

// File: rtl/ixreg_uart_regs.sv
module ixreg_uart_regs
  import ixreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [DW-1:0]   rx_hold,
  input  logic            st_upd,
  input  logic [DW-1:0]   st_line,
  input  logic [DW-1:0]   st_irq,
  input  logic [LVLW-1:0] st_rxlvl,
  input  logic [LVLW-1:0] st_txlvl,
  input  logic [DLTW-1:0] st_mdelta,
  input  logic            dcd_i,
  input  logic            ri_i,
  input  logic            dsr_i,
  input  logic            cts_i,
  input  logic            tx_serial,
  output logic            thr_wr,
  output logic [DW-1:0]   thr_wdata,
  output logic            sout,
  output logic            rts_n,
  output logic            dtr_n
);
  rst_req_t               req;
  logic [DW-1:0]          dll_q, dlm_q, ier_q, lcr_q, spr_q;
  logic [MCRW-1:0]        mcr_q;
  logic [N_RW-1:0][DW-1:0] bank_q;
  logic [DW-1:0]          lsr_q, isr_q;
  logic [LVLW-1:0]        rfl_q, tfl_q;
  logic [DLTW-1:0]        mdl_q;
  logic                   any_rst, lock, dlab;
  logic                   idx_we, soft_trig, chan_trig;
  logic [DW-1:0]          idx_rd, rd_mux;

  assign any_rst = req.full | req.chan;
  assign lock    = (lcr_q == LCR_LOCK);
  assign dlab    = lcr_q[DLAB_BIT];
  assign idx_we  = bus_wr && (bus_addr == A_IDX) && !lock;
  assign soft_trig = idx_we && (spr_q == OW'(OFF_COR)) && bus_wdata[SRST_BIT];
  assign chan_trig = idx_we && (spr_q == OW'(OFF_CSR)) && (bus_wdata == '0);

  ixreg_rst_ctl u_rst (
    .clk       (clk),
    .rst       (rst),
    .soft_trig (soft_trig),
    .chan_trig (chan_trig),
    .req       (req)
  );

  ixreg_bank #(.BDW(DW), .BOW(OW), .NREG(N_RW)) u_bank (
    .clk   (clk),
    .req   (req),
    .we    (idx_we),
    .off   (spr_q),
    .wdata (bus_wdata),
    .regs  (bank_q)
  );

  ixreg_status #(.SDW(DW), .SLW(LVLW), .SDLW(DLTW)) u_sts (
    .clk      (clk),
    .req      (req),
    .upd      (st_upd),
    .line_i   (st_line),
    .irq_i    (st_irq),
    .rxlvl_i  (st_rxlvl),
    .txlvl_i  (st_txlvl),
    .mdelta_i (st_mdelta),
    .line_q   (lsr_q),
    .irq_q    (isr_q),
    .rxlvl_q  (rfl_q),
    .txlvl_q  (tfl_q),
    .mdelta_q (mdl_q)
  );

  // Directly addressed registers
  always_ff @(posedge clk) begin
    if (any_rst) begin
      dll_q <= DLL_RST;
      dlm_q <= '0;
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      spr_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_RXTX: if (dlab) dll_q <= bus_wdata;
        A_IER:  if (dlab) dlm_q <= bus_wdata; else ier_q <= bus_wdata;
        A_LCR:  lcr_q <= bus_wdata;
        A_MCR:  mcr_q <= bus_wdata[MCRW-1:0];
        A_OFS:  if (!lock) spr_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // Transmit byte strobe
  always_ff @(posedge clk) begin
    if (any_rst) begin
      thr_wr    <= 1'b0;
      thr_wdata <= '0;
    end else begin
      thr_wr <= bus_wr && (bus_addr == A_RXTX) && !dlab;
      if (bus_wr && (bus_addr == A_RXTX) && !dlab) thr_wdata <= bus_wdata;
    end
  end

  // Indexed read selection
  always_comb begin
    idx_rd = '0;
    if (spr_q < OW'(N_RW)) begin
      idx_rd = bank_q[spr_q[$clog2(N_RW)-1:0]];
    end else begin
      case (spr_q)
        OW'(OFF_LSR): idx_rd = lsr_q;
        OW'(OFF_RFL): idx_rd = DW'(rfl_q);
        OW'(OFF_TFL): idx_rd = DW'(tfl_q);
        default:      idx_rd = '0;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_RXTX:  rd_mux = dlab ? dll_q : rx_hold;
      A_IER:   rd_mux = dlab ? dlm_q : ier_q;
      A_ISR:   rd_mux = isr_q;
      A_LCR:   rd_mux = lcr_q;
      A_MCR:   rd_mux = DW'(mcr_q);
      A_IDX:   rd_mux = lock ? '0 : (bank_q[OFF_ACR][RDEN_BIT] ? idx_rd : rx_hold);
      A_MSR:   rd_mux = DW'({dcd_i, ri_i, dsr_i, cts_i, mdl_q});
      default: rd_mux = lock ? '0 : spr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (any_rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // Line and handshake outputs, idle high
  always_ff @(posedge clk) begin
    if (any_rst) begin
      sout  <= 1'b1;
      rts_n <= 1'b1;
      dtr_n <= 1'b1;
    end else begin
      sout  <= lcr_q[BRK_BIT] ? 1'b0 : tx_serial;
      rts_n <= ~mcr_q[1];
      dtr_n <= ~mcr_q[0];
    end
  end
endmodule

// File: rtl/ixreg_uart_chk.sv
module ixreg_uart_chk
  import ixreg_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          full_rst,
  input logic          chan_rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] rx_hold,
  input logic [DW-1:0] lcr,
  input logic [DW-1:0] spr,
  input logic [DW-1:0] acr,
  input logic [DW-1:0] cor,
  input logic [DW-1:0] cks,
  input logic [DW-1:0] cka,
  input logic          sout,
  input logic          rts_n,
  input logic          dtr_n
);
  logic rst_d;
  logic rsvd;
  always_ff @(posedge clk) rst_d <= rst;
  assign rsvd = !((spr <= OW'(OFF_CSR)) || ((spr >= OW'(OFF_LSR)) && (spr <= OW'(OFF_TFL))));

  // R2
  always_ff @(posedge clk) begin
    if (rst_d) begin
      outputs_idle_chk: assert (sout && rts_n && dtr_n);
    end
  end

  // R5
  lock_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_OFS && lcr == LCR_LOCK) |=> $stable(spr));

  // R4
  rx_path_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_IDX && lcr != LCR_LOCK && !acr[RDEN_BIT] && !full_rst && !chan_rst)
    |=> (bus_rdata == $past(rx_hold)));

  // R6
  reserved_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_IDX && lcr != LCR_LOCK && acr[RDEN_BIT] && rsvd && !full_rst && !chan_rst)
    |=> (bus_rdata == '0));

  // R7
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (full_rst) |=> (cor == '0 && acr == '0 && cks == '0 && cka == '0));

  // R8
  clock_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_rst && !full_rst && !bus_wr) |=> ($stable(cks) && $stable(cka)));
endmodule

bind ixreg_uart_regs ixreg_uart_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .full_rst  (req.full),
  .chan_rst  (req.chan),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .rx_hold   (rx_hold),
  .lcr       (lcr_q),
  .spr       (spr_q),
  .acr       (bank_q[0]),
  .cor       (bank_q[4]),
  .cks       (bank_q[2]),
  .cka       (bank_q[3]),
  .sout      (sout),
  .rts_n     (rts_n),
  .dtr_n     (dtr_n)
);

// File: tb/ixreg_uart_regs_tb.sv
module ixreg_uart_regs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [7:0] rx_hold = 8'h5A;
  logic       st_upd = 0;
  logic [7:0] st_line = 8'hFF, st_irq = 8'hFF;
  logic [6:0] st_rxlvl = 7'h7F, st_txlvl = 7'h7F;
  logic [3:0] st_mdelta = 4'hF;
  logic       dcd_i = 1, ri_i = 0, dsr_i = 1, cts_i = 0;
  logic       tx_serial = 1;
  logic       thr_wr, sout, rts_n, dtr_n;
  logic [7:0] thr_wdata;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  logic [7:0] m [0:4];
  logic [7:0] m_lsr = 8'h60;
  logic [6:0] m_rfl = 0, m_tfl = 0;

  always #5 clk = ~clk;

  ixreg_uart_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_hold(rx_hold), .st_upd(st_upd),
    .st_line(st_line), .st_irq(st_irq), .st_rxlvl(st_rxlvl), .st_txlvl(st_txlvl),
    .st_mdelta(st_mdelta), .dcd_i(dcd_i), .ri_i(ri_i), .dsr_i(dsr_i), .cts_i(cts_i),
    .tx_serial(tx_serial), .thr_wr(thr_wr), .thr_wdata(thr_wdata), .sout(sout),
    .rts_n(rts_n), .dtr_n(dtr_n));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic iwr(input logic [7:0] o, input logic [7:0] v);
    wr(3'd7, o); wr(3'd5, v);
  endtask

  task automatic ird(input logic [7:0] o, output logic [7:0] v);
    wr(3'd7, o); rd(3'd5, v);
  endtask

  function automatic logic [7:0] exp_idx(input logic [7:0] o);
    if (o <= 8'd4) return m[o[2:0]];
    case (o)
      8'd8:    return m_lsr;
      8'd9:    return {1'b0, m_rfl};
      8'd10:   return {1'b0, m_tfl};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset(input bit keep_clk);
    m[0] = 0; m[1] = 8'h20; m[4] = 0;
    if (!keep_clk) begin m[2] = 0; m[3] = 0; end
    m_lsr = 8'h60; m_rfl = 0; m_tfl = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h00C0FFEE));
    model_reset(0);
    repeat (3) @(negedge clk);
    chk("R2 outputs during reset", {5'd0, sout, rts_n, dtr_n}, 8'h07);
    rst = 0;
    @(negedge clk);
    chk("R2 outputs after reset", {5'd0, sout, rts_n, dtr_n}, 8'h07);

    // R1 direct register reset values, R11 divisor routing
    rd(3'd3, v); chk("R1 LCR reset", v, 8'h00);
    rd(3'd1, v); chk("R1 IER reset", v, 8'h00);
    rd(3'd4, v); chk("R1 MCR reset", v, 8'h00);
    wr(3'd3, 8'h80);
    rd(3'd0, v); chk("R1 DLL reset", v, 8'h01);
    rd(3'd1, v); chk("R1 DLM reset", v, 8'h00);
    wr(3'd1, 8'h9C); rd(3'd1, v); chk("R11 DLM write", v, 8'h9C);
    wr(3'd3, 8'h00);
    rd(3'd1, v); chk("R11 IER separate from DLM", v, 8'h00);
    rd(3'd0, v); chk("R11 addr0 reads rx_hold", v, 8'h5A);

    // R4 read enable clear: rx path
    wr(3'd7, 8'h01); rd(3'd5, v); chk("R4 enable clear gives rx_hold", v, 8'h5A);
    rd(3'd7, v); chk("R3 offset readback", v, 8'h01);

    // R1 status snapshot, R3 indexed path
    iwr(8'h00, 8'h40); m[0] = 8'h40;
    ird(8'h01, v); chk("R1 CPR reset", v, 8'h20);
    ird(8'h08, v); chk("R1 LSR reset", v, 8'h60);
    ird(8'h09, v); chk("R1 RFL reset", v, 8'h00);
    ird(8'h0A, v); chk("R1 TFL reset", v, 8'h00);
    rd(3'd2, v); chk("R1 ISR reset", v, 8'h01);
    rd(3'd6, v); chk("R9 MSR after reset", v, 8'hA0);
    dcd_i = 0; ri_i = 1; dsr_i = 0; cts_i = 1;
    rd(3'd6, v); chk("R9 MSR live lines", v, 8'h50);

    // R4 clear the enable, normal path returns
    iwr(8'h00, 8'h00); rx_hold = 8'hC3;
    rd(3'd5, v); chk("R4 enable cleared", v, 8'hC3);
    iwr(8'h00, 8'h40);

    // R3 R6 random indexed traffic
    for (int i = 0; i < 300; i++) begin
      logic [7:0] o, d, ro;
      o = 8'($urandom());
      if ($urandom() % 2) o = 8'($urandom() % 12);
      d = 8'($urandom());
      if (o == 8'd0) d = d | 8'h40;
      if (o == 8'd4) d = d & 8'h7F;
      if (o == 8'd5) d = d | 8'h01;
      iwr(o, d);
      if (o <= 8'd4) m[o[2:0]] = d;
      ro = ($urandom() % 2) ? o : 8'($urandom() % 12);
      ird(ro, v);
      chk($sformatf("R6 R3 random off=%h", ro), v, exp_idx(ro));
    end

    // R10 status update
    iwr(8'h00, 8'h40); m[0] = 8'h40;
    @(negedge clk);
    st_line = 8'h21; st_irq = 8'hC4; st_rxlvl = 7'd17; st_txlvl = 7'd99; st_mdelta = 4'h9;
    st_upd = 1; @(negedge clk); st_upd = 0;
    st_line = 8'h00; st_irq = 8'h00; st_rxlvl = 0; st_txlvl = 0; st_mdelta = 0;
    m_lsr = 8'h21; m_rfl = 7'd17; m_tfl = 7'd99;
    ird(8'h08, v); chk("R10 LSR loaded", v, 8'h21);
    ird(8'h09, v); chk("R10 RFL loaded", v, 8'd17);
    ird(8'h0A, v); chk("R10 TFL loaded", v, 8'd99);
    rd(3'd2, v); chk("R10 ISR loaded", v, 8'hC4);
    rd(3'd6, v); chk("R9 MSR delta nibble", v, 8'h59);

    // R5 lockout
    wr(3'd7, 8'h02); iwr(8'h02, 8'h3C); m[2] = 8'h3C;
    wr(3'd3, 8'hBF);
    wr(3'd7, 8'h01); wr(3'd5, 8'h77);
    rd(3'd5, v); chk("R5 lock read addr5", v, 8'h00);
    rd(3'd7, v); chk("R5 lock read addr7", v, 8'h00);
    wr(3'd3, 8'h03);
    rd(3'd7, v); chk("R5 offset unchanged", v, 8'h02);
    rd(3'd5, v); chk("R5 indexed unchanged", v, 8'h3C);

    // R11 transmit strobe
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'hA7; bus_wr = 1;
    @(posedge clk); #1;
    chk("R11 thr_wr pulse", {7'd0, thr_wr}, 8'h01);
    chk("R11 thr_wdata", thr_wdata, 8'hA7);
    @(negedge clk); bus_wr = 0;
    @(posedge clk); #1;
    chk("R11 thr_wr one cycle", {7'd0, thr_wr}, 8'h00);

    // R12 modem control and break
    wr(3'd4, 8'h01); @(negedge clk);
    chk("R12 dtr only", {6'd0, rts_n, dtr_n}, 8'h02);
    wr(3'd4, 8'h02); @(negedge clk);
    chk("R12 rts only", {6'd0, rts_n, dtr_n}, 8'h01);
    tx_serial = 0; @(negedge clk); @(negedge clk);
    chk("R12 sout follows tx", {7'd0, sout}, 8'h00);
    tx_serial = 1; wr(3'd3, 8'h43); @(negedge clk);
    chk("R12 break forces low", {7'd0, sout}, 8'h00);
    wr(3'd3, 8'h03); @(negedge clk);
    chk("R12 break released", {7'd0, sout}, 8'h01);

    // R8 channel reset
    iwr(8'h01, 8'h33); m[1] = 8'h33;
    iwr(8'h03, 8'h22); m[3] = 8'h22;
    iwr(8'h02, 8'h11); m[2] = 8'h11;
    iwr(8'h05, 8'h01);
    ird(8'h01, v); chk("R8 nonzero CSR no effect", v, 8'h33);
    wr(3'd3, 8'h80); wr(3'd0, 8'h44); wr(3'd3, 8'h03);
    wr(3'd4, 8'h03);
    iwr(8'h05, 8'h00); model_reset(1);
    @(negedge clk);
    chk("R8 handshake idle", {6'd0, rts_n, dtr_n}, 8'h03);
    rd(3'd3, v); chk("R8 LCR cleared", v, 8'h00);
    rd(3'd7, v); chk("R8 offset cleared", v, 8'h00);
    rd(3'd5, v); chk("R8 ACR cleared", v, rx_hold);
    iwr(8'h00, 8'h40); m[0] = 8'h40;
    ird(8'h02, v); chk("R8 CKS kept", v, 8'h11);
    ird(8'h03, v); chk("R8 CKA kept", v, 8'h22);
    ird(8'h01, v); chk("R8 CPR restored", v, 8'h20);
    ird(8'h08, v); chk("R8 LSR restored", v, 8'h60);
    wr(3'd3, 8'h80); rd(3'd0, v); chk("R8 DLL restored", v, 8'h01);
    wr(3'd3, 8'h00);

    // R7 soft reset
    iwr(8'h04, 8'h05); m[4] = 8'h05;
    ird(8'h04, v); chk("R7 COR stored", v, 8'h05);
    iwr(8'h04, 8'h81); model_reset(0);
    iwr(8'h00, 8'h40); m[0] = 8'h40;
    ird(8'h04, v); chk("R7 COR reads 0", v, 8'h00);
    ird(8'h02, v); chk("R7 CKS cleared", v, 8'h00);
    ird(8'h03, v); chk("R7 CKA cleared", v, 8'h00);
    ird(8'h01, v); chk("R7 CPR restored", v, 8'h20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule